// File: doc/BRIEF.md
# Stack Pointer Unit with Byte-Mapped Halves

This block keeps the CPU stack pointer for a stack that grows toward lower addresses. Software sees the pointer as two byte-wide registers, a low half and a high half, through a small read/write port. The instruction sequencer raises one of four strobes: single-byte push, single-byte pop, return-address push (subroutine call or interrupt entry) and return-address pop (return from subroutine or interrupt). In that same cycle the block presents the data-memory address or addresses for the access. The pointer then moves by one for data bytes and by two for return addresses.

A push stores at the current pointer and then decrements. A pop increments first and then reads. A return-address push puts the low byte of the return address at the current pointer (first access, port A) and the high byte one address below (second access, port B). A return-address pop reads the high byte first at pointer+1 and then the low byte at pointer+2. For small data spaces a parameter removes the high half. The pointer is then 8 bits wide, reads of the high half give zero and writes to it are dropped. A sticky flag reports a pop that carries the pointer beyond the configured top of RAM.

Top module: `sp_unit`

## Requirements
- R1: After reset the pointer equals parameter RESET_VAL (default 0x08FF), the underflow flag is 0 and no access is presented.
- R2: A single-byte push presents acc_valid=1, acc_write=1, acc_two=0 and acc_addr_a equal to the current pointer, and the pointer is one lower after the clock edge.
- R3: A single-byte pop presents acc_valid=1, acc_write=0, acc_two=0 and acc_addr_a equal to pointer+1, and the pointer is one higher after the edge.
- R4: A return-address push presents acc_write=1 and acc_two=1, with acc_addr_a equal to the pointer (low byte of the return address) and acc_addr_b equal to pointer-1 (high byte). The pointer is two lower after the edge.
- R5: A return-address pop presents acc_write=0 and acc_two=1, with acc_addr_a equal to pointer+1 (high byte) and acc_addr_b equal to pointer+2 (low byte). The pointer is two higher after the edge.
- R6: A register write with reg_hi=0 loads bits 7:0 of the pointer, and one with reg_hi=1 loads the bits above bit 7. The other half is unchanged. reg_rdata shows the half picked by reg_hi in the same cycle.
- R7: When a register write and a stack strobe come in the same cycle, the write is dropped and the stack operation is applied.
- R8: When several strobes are raised together, only one operation is applied, chosen with the priority return-address push, then return-address pop, then push, then pop.
- R9: If a pop or return-address pop produces a pointer above parameter RAM_TOP (the sum taken one bit wider than the pointer, so a wrap past the all-ones value also counts), the underflow output becomes 1 after the edge. It stays 1 until a register write is applied.
- R10: With HAS_HIGH=0 the pointer is 8 bits and wraps modulo 256. A read with reg_hi=1 returns 0x00, a write with reg_hi=1 changes nothing, and the access addresses carry zeros above bit 7.
- R11: With no strobe and no write, the pointer holds, and acc_valid, acc_write and acc_two are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_hi | input | 1 | Half select for read and write (1 = high half) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Selected half of the pointer |
| op_push | input | 1 | Single-byte push strobe |
| op_pop | input | 1 | Single-byte pop strobe |
| op_call | input | 1 | Return-address push strobe |
| op_ret | input | 1 | Return-address pop strobe |
| acc_valid | output | 1 | A stack access is presented this cycle |
| acc_write | output | 1 | Access is a store (1) or a load (0) |
| acc_two | output | 1 | Second access on acc_addr_b is also valid |
| acc_addr_a | output | ADDR_W | Address of the first byte accessed |
| acc_addr_b | output | ADDR_W | Address of the second byte accessed |
| underflow | output | 1 | Sticky flag: pointer moved past RAM_TOP |

## Verification
Two kinds of collision can land on one clock edge: a software write to a pointer half together with a stack strobe, and two different stack strobes together. The vector table contains rows that raise a low-half write with a push, a return-address push with a pop, a return-address pop with a push, and a push with a pop. For each row the bench checks the presented addresses in that cycle and reads both halves back afterwards. The expected pointer is the one from the winning operation alone, with the write discarded. A separate sequence drives a pop onto exactly RAM_TOP and then one past it, confirms that the flag stays set through an idle cycle, and confirms that it clears on a write.

// File: rtl/sp_pkg.sv
`timescale 1ns/1ps
package sp_pkg;

   typedef enum logic [2:0] {
      SP_IDLE = 3'd0,
      SP_PUSH = 3'd1,
      SP_POP  = 3'd2,
      SP_CALL = 3'd3,
      SP_RET  = 3'd4
   } sp_op_e;

   // operations that move the pointer upward and may overrun RAM top
   function automatic logic sp_op_is_up(input sp_op_e op);
      return (op == SP_POP) || (op == SP_RET);
   endfunction

   // operations that touch two bytes
   function automatic logic sp_op_is_pair(input sp_op_e op);
      return (op == SP_CALL) || (op == SP_RET);
   endfunction

endpackage

// File: rtl/sp_op_decode.sv
`timescale 1ns/1ps
module sp_op_decode
   import sp_pkg::*;
(
   input  logic   st_push,
   input  logic   st_pop,
   input  logic   st_call,
   input  logic   st_ret,
   output sp_op_e op
);

   // fixed priority: two-byte push, two-byte pop, byte push, byte pop
   always_comb begin
      if (st_call)      op = SP_CALL;
      else if (st_ret)  op = SP_RET;
      else if (st_push) op = SP_PUSH;
      else if (st_pop)  op = SP_POP;
      else              op = SP_IDLE;
   end

endmodule

// File: rtl/sp_addr_gen.sv
`timescale 1ns/1ps
module sp_addr_gen
   import sp_pkg::*;
#(
   parameter int unsigned        SP_W = 16,
   parameter logic [SP_W-1:0]    TOP  = '1
) (
   input  logic [SP_W-1:0] sp,
   input  sp_op_e          op,
   output logic            valid,
   output logic            write,
   output logic            two,
   output logic [SP_W-1:0] addr_a,
   output logic [SP_W-1:0] addr_b,
   output logic [SP_W-1:0] sp_next,
   output logic            overrun
);

   localparam int unsigned XW = SP_W + 1;
   localparam logic [XW-1:0] TOP_X = {1'b0, TOP};

   logic [XW-1:0]   up1, up2;
   logic [SP_W-1:0] dn1, dn2;

   assign up1 = {1'b0, sp} + XW'(1);
   assign up2 = {1'b0, sp} + XW'(2);
   assign dn1 = sp - SP_W'(1);
   assign dn2 = sp - SP_W'(2);

   always_comb begin
      valid   = 1'b0;
      write   = 1'b0;
      two     = sp_op_is_pair(op);
      addr_a  = sp;
      addr_b  = sp;
      sp_next = sp;
      overrun = 1'b0;
      unique case (op)
         SP_PUSH: begin
            valid   = 1'b1;
            write   = 1'b1;
            sp_next = dn1;
         end
         SP_POP: begin
            valid   = 1'b1;
            addr_a  = up1[SP_W-1:0];
            sp_next = up1[SP_W-1:0];
            overrun = up1 > TOP_X;
         end
         SP_CALL: begin
            valid   = 1'b1;
            write   = 1'b1;
            addr_b  = dn1;
            sp_next = dn2;
         end
         SP_RET: begin
            valid   = 1'b1;
            addr_a  = up1[SP_W-1:0];
            addr_b  = up2[SP_W-1:0];
            sp_next = up2[SP_W-1:0];
            overrun = up2 > TOP_X;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/sp_store.sv
`timescale 1ns/1ps
module sp_store #(
   parameter int unsigned     SP_W     = 16,
   parameter bit              HAS_HIGH = 1'b1,
   parameter logic [SP_W-1:0] INIT     = '1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load_en,
   input  logic [SP_W-1:0] load_val,
   input  logic            wr_en,
   input  logic            wr_hi,
   input  logic [7:0]      wdata,
   input  logic            rd_hi,
   output logic [7:0]      rdata,
   output logic [SP_W-1:0] sp
);

   logic [7:0] lo_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 lo_q <= INIT[7:0];
      else if (load_en)           lo_q <= load_val[7:0];
      else if (wr_en && !wr_hi)   lo_q <= wdata;
   end

   generate
      if (HAS_HIGH) begin : g_wide
         localparam int unsigned HW = SP_W - 8;
         logic [HW-1:0] hi_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)               hi_q <= INIT[SP_W-1:8];
            else if (load_en)         hi_q <= load_val[SP_W-1:8];
            else if (wr_en && wr_hi)  hi_q <= wdata[HW-1:0];
         end

         assign sp    = {hi_q, lo_q};
         assign rdata = rd_hi ? 8'(hi_q) : lo_q;

         // R6: writing the high half leaves the low half alone
         a_r6_hi_write_keeps_lo: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_hi && !load_en) |=> (lo_q == $past(lo_q)));
      end else begin : g_narrow
         assign sp    = lo_q;
         assign rdata = rd_hi ? 8'h00 : lo_q;
      end
   endgenerate

   // R7: a stack update wins over a concurrent register write
   a_r7_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
      load_en |=> (sp == $past(load_val)));

endmodule

// File: rtl/sp_unit.sv
`timescale 1ns/1ps
module sp_unit
   import sp_pkg::*;
#(
   parameter int unsigned        ADDR_W    = 16,
   parameter bit                 HAS_HIGH  = 1'b1,
   parameter logic [ADDR_W-1:0]  RESET_VAL = 16'h08FF,
   parameter logic [ADDR_W-1:0]  RAM_TOP   = 16'h08FF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic              reg_hi,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   input  logic              op_push,
   input  logic              op_pop,
   input  logic              op_call,
   input  logic              op_ret,
   output logic              acc_valid,
   output logic              acc_write,
   output logic              acc_two,
   output logic [ADDR_W-1:0] acc_addr_a,
   output logic [ADDR_W-1:0] acc_addr_b,
   output logic              underflow
);

   localparam int unsigned SP_W = HAS_HIGH ? ADDR_W : 8;
   localparam logic [SP_W-1:0] INIT_SP = SP_W'(RESET_VAL);
   localparam logic [SP_W-1:0] TOP_SP  = SP_W'(RAM_TOP);

   generate
      if (ADDR_W < 9 || ADDR_W > 16) begin : g_bad_width
         $error("sp_unit: ADDR_W must lie in 9..16");
      end
      if (!HAS_HIGH && (RESET_VAL > 255 || RAM_TOP > 255)) begin : g_bad_small
         $error("sp_unit: without high half, RESET_VAL and RAM_TOP must fit 8 bits");
      end
      if (RESET_VAL > RAM_TOP) begin : g_bad_init
         $error("sp_unit: RESET_VAL must not exceed RAM_TOP");
      end
   endgenerate

   sp_op_e          op;
   logic [SP_W-1:0] sp_q, sp_nxt, a_sp, b_sp;
   logic            ovr, op_live;

   sp_op_decode u_dec (
      .st_push (op_push),
      .st_pop  (op_pop),
      .st_call (op_call),
      .st_ret  (op_ret),
      .op      (op)
   );

   sp_addr_gen #(.SP_W(SP_W), .TOP(TOP_SP)) u_agen (
      .sp      (sp_q),
      .op      (op),
      .valid   (acc_valid),
      .write   (acc_write),
      .two     (acc_two),
      .addr_a  (a_sp),
      .addr_b  (b_sp),
      .sp_next (sp_nxt),
      .overrun (ovr)
   );

   assign op_live = (op != SP_IDLE);

   sp_store #(.SP_W(SP_W), .HAS_HIGH(HAS_HIGH), .INIT(INIT_SP)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_en  (op_live),
      .load_val (sp_nxt),
      .wr_en    (reg_we),
      .wr_hi    (reg_hi),
      .wdata    (reg_wdata),
      .rd_hi    (reg_hi),
      .rdata    (reg_rdata),
      .sp       (sp_q)
   );

   assign acc_addr_a = ADDR_W'(a_sp);
   assign acc_addr_b = ADDR_W'(b_sp);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   underflow <= 1'b0;
      else if (ovr)                 underflow <= 1'b1;
      else if (reg_we && !op_live)  underflow <= 1'b0;
   end

   // R2
   a_r2_push_dec: assert property (@(posedge clk) disable iff (!rst_n)
      (op == SP_PUSH) |=> (sp_q == $past(sp_q) - SP_W'(1)));
   // R3
   a_r3_pop_inc: assert property (@(posedge clk) disable iff (!rst_n)
      (op == SP_POP) |=> (sp_q == $past(sp_q) + SP_W'(1)));
   // R4
   a_r4_call_dec2: assert property (@(posedge clk) disable iff (!rst_n)
      (op == SP_CALL) |=> (sp_q == $past(sp_q) - SP_W'(2)));
   // R5
   a_r5_ret_inc2: assert property (@(posedge clk) disable iff (!rst_n)
      (op == SP_RET) |=> (sp_q == $past(sp_q) + SP_W'(2)));
   // R8: a two-byte push strobe always selects the two-byte push
   a_r8_call_first: assert property (@(posedge clk) disable iff (!rst_n)
      op_call |-> (acc_two && acc_write));
   // R9: flag is sticky until an applied write
   a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (underflow && !(reg_we && !op_live)) |=> underflow);
   // R11: idle holds the pointer
   a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!op_live && !reg_we) |=> $stable(sp_q));

   generate
      if (!HAS_HIGH) begin : g_small_chk
         // R10: missing high half reads as zero
         a_r10_hi_zero: assert property (@(posedge clk) disable iff (!rst_n)
            reg_hi |-> (reg_rdata == 8'h00));
      end
   endgenerate

endmodule

// File: tb/tb_sp_unit.sv
`timescale 1ns/1ps
module tb_sp_unit;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   // main instance
   logic        we = 0, hi = 0, push = 0, pop = 0, call = 0, ret = 0;
   logic [7:0]  wd = 0, rd;
   logic        av, aw, a2, uf;
   logic [15:0] aa, ab;

   sp_unit dut (
      .clk(clk), .rst_n(rst_n), .reg_we(we), .reg_hi(hi), .reg_wdata(wd),
      .reg_rdata(rd), .op_push(push), .op_pop(pop), .op_call(call), .op_ret(ret),
      .acc_valid(av), .acc_write(aw), .acc_two(a2), .acc_addr_a(aa),
      .acc_addr_b(ab), .underflow(uf)
   );

   // small instance, no high half
   logic        s_we = 0, s_hi = 0, s_push = 0, s_pop = 0;
   logic [7:0]  s_wd = 0, s_rd;
   logic        s_av, s_aw, s_a2, s_uf;
   logic [15:0] s_aa, s_ab;

   sp_unit #(.HAS_HIGH(1'b0), .RESET_VAL(16'h00DF), .RAM_TOP(16'h00DF)) dut_s (
      .clk(clk), .rst_n(rst_n), .reg_we(s_we), .reg_hi(s_hi), .reg_wdata(s_wd),
      .reg_rdata(s_rd), .op_push(s_push), .op_pop(s_pop), .op_call(1'b0),
      .op_ret(1'b0), .acc_valid(s_av), .acc_write(s_aw), .acc_two(s_a2),
      .acc_addr_a(s_aa), .acc_addr_b(s_ab), .underflow(s_uf)
   );

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // ops = {call, ret, push, pop}
   typedef struct packed {
      logic [3:0]  ops;
      logic        w;
      logic        h;
      logic [7:0]  d;
      logic [15:0] ea;
      logic [15:0] eb;
      logic [15:0] esp;
   } vec_t;

   localparam vec_t VECS [16] = '{
      '{4'b0010, 1'b0, 1'b0, 8'h00, 16'h08FF, 16'h0000, 16'h08FE}, // R2
      '{4'b0010, 1'b0, 1'b0, 8'h00, 16'h08FE, 16'h0000, 16'h08FD}, // R2
      '{4'b1000, 1'b0, 1'b0, 8'h00, 16'h08FD, 16'h08FC, 16'h08FB}, // R4
      '{4'b0001, 1'b0, 1'b0, 8'h00, 16'h08FC, 16'h0000, 16'h08FC}, // R3
      '{4'b0100, 1'b0, 1'b0, 8'h00, 16'h08FD, 16'h08FE, 16'h08FE}, // R5
      '{4'b0000, 1'b1, 1'b0, 8'h10, 16'h0000, 16'h0000, 16'h0810}, // R6 low
      '{4'b0000, 1'b1, 1'b1, 8'h01, 16'h0000, 16'h0000, 16'h0110}, // R6 high
      '{4'b1000, 1'b0, 1'b0, 8'h00, 16'h0110, 16'h010F, 16'h010E}, // R4
      '{4'b0010, 1'b1, 1'b0, 8'h55, 16'h010E, 16'h0000, 16'h010D}, // R7
      '{4'b1001, 1'b0, 1'b0, 8'h00, 16'h010D, 16'h010C, 16'h010B}, // R8
      '{4'b0110, 1'b0, 1'b0, 8'h00, 16'h010C, 16'h010D, 16'h010D}, // R8
      '{4'b0011, 1'b0, 1'b0, 8'h00, 16'h010D, 16'h0000, 16'h010C}, // R8
      '{4'b0001, 1'b0, 1'b0, 8'h00, 16'h010D, 16'h0000, 16'h010D}, // R3
      '{4'b0000, 1'b1, 1'b0, 8'hFF, 16'h0000, 16'h0000, 16'h01FF}, // R6
      '{4'b0001, 1'b0, 1'b0, 8'h00, 16'h0200, 16'h0000, 16'h0200}, // R3 carry
      '{4'b0010, 1'b0, 1'b0, 8'h00, 16'h0200, 16'h0000, 16'h01FF}  // R2 borrow
   };

   task automatic read_sp(output logic [15:0] v);
      hi = 1'b0; #0.5 v[7:0] = rd;
      hi = 1'b1; #0.5 v[15:8] = rd;
      hi = 1'b0;
   endtask

   task automatic s_read(output logic [7:0] lo, output logic [7:0] hv);
      s_hi = 1'b0; #0.5 lo = s_rd;
      s_hi = 1'b1; #0.5 hv = s_rd;
      s_hi = 1'b0;
   endtask

   // apply one cycle of stimulus on the main instance, check the
   // access outputs in that cycle and return the pointer afterwards
   task automatic step(input logic [3:0] ops, input logic w, input logic h,
                       input logic [7:0] d, input string tag,
                       input logic [15:0] ea, input logic [15:0] eb,
                       output logic [15:0] sp_after);
      logic ev, ew, e2;
      @(negedge clk);
      {call, ret, push, pop} = ops;
      we = w; hi = h; wd = d;
      // expected access type from the winning strobe (R8 priority)
      if (ops[3])      begin ev = 1; ew = 1; e2 = 1; end
      else if (ops[2]) begin ev = 1; ew = 0; e2 = 1; end
      else if (ops[1]) begin ev = 1; ew = 1; e2 = 0; end
      else if (ops[0]) begin ev = 1; ew = 0; e2 = 0; end
      else             begin ev = 0; ew = 0; e2 = 0; end
      #0.5;
      chk({tag, " acc_valid"}, 32'(av), 32'(ev));
      chk({tag, " acc_write"}, 32'(aw), 32'(ew));
      chk({tag, " acc_two"},   32'(a2), 32'(e2));
      if (ev)  chk({tag, " addr_a"}, 32'(aa), 32'(ea));
      if (e2)  chk({tag, " addr_b"}, 32'(ab), 32'(eb));
      @(negedge clk);
      {call, ret, push, pop} = 4'b0000;
      we = 0; wd = 0;
      read_sp(sp_after);
   endtask

   task automatic s_step(input logic p, input logic q, input logic w,
                         input logic h, input logic [7:0] d);
      @(negedge clk);
      s_push = p; s_pop = q; s_we = w; s_hi = h; s_wd = d;
      #0.5;
   endtask

   task automatic s_idle();
      @(negedge clk);
      s_push = 0; s_pop = 0; s_we = 0; s_wd = 0; s_hi = 0;
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      logic [15:0] v;
      logic [7:0]  lo, hv;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      read_sp(v);
      chk("R1 reset pointer", 32'(v), 32'h08FF);
      chk("R1 reset underflow", 32'(uf), 32'h0);
      chk("R11 idle acc_valid", 32'(av), 32'h0);

      // vector table
      for (int i = 0; i < 16; i++) begin
         step(VECS[i].ops, VECS[i].w, VECS[i].h, VECS[i].d,
              $sformatf("R2/R3/R4/R5/R6/R7/R8 vec%0d", i),
              VECS[i].ea, VECS[i].eb, v);
         chk($sformatf("vec%0d pointer", i), 32'(v), 32'(VECS[i].esp));
      end
      chk("R9 no flag in normal run", 32'(uf), 32'h0);

      // R11 idle holds
      step(4'b0000, 1'b0, 1'b0, 8'h00, "R11 idle", 16'h0, 16'h0, v);
      chk("R11 pointer held", 32'(v), 32'h01FF);

      // R9 underflow boundary
      step(4'b0000, 1'b1, 1'b1, 8'h08, "R6 set hi", 16'h0, 16'h0, v);
      step(4'b0000, 1'b1, 1'b0, 8'hFE, "R6 set lo", 16'h0, 16'h0, v);
      chk("R6 pointer 08FE", 32'(v), 32'h08FE);
      step(4'b0001, 1'b0, 1'b0, 8'h00, "R9 pop to top", 16'h08FF, 16'h0, v);
      chk("R9 exactly top no flag", 32'(uf), 32'h0);
      step(4'b0001, 1'b0, 1'b0, 8'h00, "R9 pop past top", 16'h0900, 16'h0, v);
      chk("R9 flag raised", 32'(uf), 32'h1);
      chk("R9 pointer still moves", 32'(v), 32'h0900);
      step(4'b0000, 1'b0, 1'b0, 8'h00, "R9 idle", 16'h0, 16'h0, v);
      chk("R9 flag sticky", 32'(uf), 32'h1);
      step(4'b0000, 1'b1, 1'b0, 8'h00, "R9 write", 16'h0, 16'h0, v);
      chk("R9 flag cleared by write", 32'(uf), 32'h0);
      chk("R9 pointer after write", 32'(v), 32'h0900);

      // R10 small variant
      s_read(lo, hv);
      chk("R10 small reset lo", 32'(lo), 32'hDF);
      chk("R10 small hi reads zero", 32'(hv), 32'h00);
      s_step(0, 0, 1, 1, 8'h33);
      s_idle();
      s_read(lo, hv);
      chk("R10 hi write ignored (hi)", 32'(hv), 32'h00);
      chk("R10 hi write ignored (lo)", 32'(lo), 32'hDF);
      s_step(1, 0, 0, 0, 8'h00);
      chk("R10 small push addr", 32'(s_aa), 32'h00DF);
      s_idle();
      s_read(lo, hv);
      chk("R10 small push pointer", 32'(lo), 32'hDE);
      s_step(0, 0, 1, 0, 8'h00);
      s_idle();
      s_step(1, 0, 0, 0, 8'h00);
      chk("R10 small push at zero addr", 32'(s_aa), 32'h0000);
      s_idle();
      s_read(lo, hv);
      chk("R10 small wrap to FF", 32'(lo), 32'hFF);
      s_step(0, 1, 0, 0, 8'h00);
      chk("R10 small pop wraps addr", 32'(s_aa), 32'h0000);
      s_idle();
      #0.5;
      chk("R9 small overrun flag", 32'(s_uf), 32'h1);

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule